// File: doc/BRIEF.md
# Pipelined 32-bit Integer ALU with Lookahead Carry Tree

This block is a 32-bit arithmetic and logic unit with a register stage on each side. On every rising clock edge the two operand inputs are loaded into a pair of operand registers. The combinational datapath between those registers and the output register does one of seven operations, or gives a zero word. A 3-bit operation code selects the operation. The result is loaded into an output register, and that register drives the result bus.

The operation code and the carry input are not registered. They act directly on the operands already held in the operand registers. A caller therefore presents operands in one cycle and the matching operation and carry in the next cycle, and reads the result after the second clock edge. A new operand set may be issued every cycle. Carries for add and subtract come from a tree of two-input lookahead cells, nested down to single bits. The block has no reset. The output is defined two edges after the first operands are loaded.

Top module: `alu32_pipe`

## Requirements
- R1: At each rising edge, `opa_in` is loaded into the A operand register.
- R2: At each rising edge, `opb_in` is loaded into the B operand register.
- R3: `result_out` comes only from the output register. A result is loaded at the edge after its operands were loaded, so it appears two edges after the operands are presented. Between those edges `result_out` keeps its previous value.
- R4: `op_sel` and `carry_in` are not registered. They must be valid in the cycle after the operand edge, and the next edge loads the result for that cycle's `op_sel`/`carry_in` applied to the held operands.
- R5: The logic operations have these codes: 3'b000 A XOR B, 3'b001 A XNOR B, 3'b100 A OR B, 3'b101 A NOR B, 3'b110 A AND B.
- R6: Code 3'b010 gives A + B + carry_in modulo 2^32. The carry out of bit 31 equals bit 32 of the full-width sum.
- R7: Code 3'b011 gives A + ~B + carry_in modulo 2^32. With carry_in = 1 this is A - B, and with carry_in = 0 it is A - B - 1.
- R8: Code 3'b111 gives 32'h0000_0000 whatever the operands are.
- R9: `carry_in` has no effect on the result of any logic operation or of code 3'b111.
- R10: Arithmetic wraps modulo 2^32. 32'hFFFF_FFFF + 1 gives 0, and 0 - 1 gives 32'hFFFF_FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all three registers |
| opa_in | input | 32 | Operand A, loaded at each edge |
| opb_in | input | 32 | Operand B, loaded at each edge |
| op_sel | input | 3 | Operation code, applied directly to the held operands |
| carry_in | input | 1 | Carry input, used by add and subtract only |
| result_out | output | 32 | Registered result |

## Verification
A result is due two rising edges after its operands are driven, and one edge after the matching `op_sel` and `carry_in` are driven. The directed tasks drive inputs on falling edges and read `result_out` on the falling edge after the second rising edge. The latency task also reads once after only one edge, to confirm that the output has not yet changed. The streaming task issues new operands every cycle with the operation code one cycle behind. It compares the output against the vector issued two cycles earlier, which checks both the two-edge latency and the one-cycle offset of the unregistered controls.

// File: rtl/alu_pipe_pkg.sv
package alu_pipe_pkg;

  localparam int DATA_W = 32;

  typedef enum logic [2:0] {
    OP_XOR  = 3'b000,
    OP_XNOR = 3'b001,
    OP_ADD  = 3'b010,
    OP_SUB  = 3'b011,
    OP_OR   = 3'b100,
    OP_NOR  = 3'b101,
    OP_AND  = 3'b110,
    OP_ZERO = 3'b111
  } alu_op_e;

  // One result bit. prop is the half-sum of a and the possibly inverted b.
  // cin_g is the carry already gated by the arithmetic select bit.
  function automatic logic bit_result(logic a, logic b, logic [2:0] sel,
                                      logic prop, logic cin_g);
    logic r;
    case (alu_op_e'(sel))
      OP_XOR:  r = a ^ b;
      OP_XNOR: r = ~(a ^ b);
      OP_ADD,
      OP_SUB:  r = prop ^ cin_g;
      OP_OR:   r = a | b;
      OP_NOR:  r = ~(a | b);
      OP_AND:  r = a & b;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

  // Word-level model, written with native arithmetic.
  function automatic logic [DATA_W-1:0] word_model(logic [DATA_W-1:0] a,
                                                   logic [DATA_W-1:0] b,
                                                   logic [2:0] sel,
                                                   logic cin);
    logic [DATA_W:0] ext;
    logic [DATA_W-1:0] r;
    ext = '0;
    case (alu_op_e'(sel))
      OP_XOR:  r = a ^ b;
      OP_XNOR: r = ~(a ^ b);
      OP_ADD: begin
        ext = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
        r   = ext[DATA_W-1:0];
      end
      OP_SUB: begin
        ext = {1'b0, a} + {1'b0, ~b} + {{DATA_W{1'b0}}, cin};
        r   = ext[DATA_W-1:0];
      end
      OP_OR:   r = a | b;
      OP_NOR:  r = ~(a | b);
      OP_AND:  r = a & b;
      default: r = '0;
    endcase
    return r;
  endfunction

  // Carry out of the top bit for add.
  function automatic logic add_carry(logic [DATA_W-1:0] a,
                                     logic [DATA_W-1:0] b, logic cin);
    logic [DATA_W:0] ext;
    ext = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
    return ext[DATA_W];
  endfunction

endpackage

// File: rtl/pipe_reg.sv
module pipe_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    q <= d;
  end
endmodule

// File: rtl/la_cell.sv
// Two-input lookahead cell: merges two generate/propagate pairs and
// splits the incoming carry to the two halves.
module la_cell (
  input  logic [1:0] g,
  input  logic [1:0] p,
  input  logic       cin,
  output logic [1:0] c,
  output logic       gg,
  output logic       gp
);
  assign gg   = g[1] | (g[0] & p[1]);
  assign gp   = p[1] & p[0];
  assign c[0] = cin;
  assign c[1] = g[0] | (p[0] & cin);
endmodule

// File: rtl/la_tree.sv
// Recursive lookahead tree. W must be a power of two, at least 2.
module la_tree #(
  parameter int W = 32
) (
  input  logic [W-1:0] g,
  input  logic [W-1:0] p,
  input  logic         cin,
  output logic [W-1:0] c,
  output logic         gg,
  output logic         gp
);
  localparam int H = W / 2;

  generate
    if (W == 2) begin : g_leaf
      la_cell leaf_i (
        .g(g), .p(p), .cin(cin), .c(c), .gg(gg), .gp(gp)
      );
    end else begin : g_node
      logic [1:0] sub_g;
      logic [1:0] sub_p;
      logic [1:0] sub_c;

      la_tree #(.W(H)) lo_i (
        .g(g[H-1:0]), .p(p[H-1:0]), .cin(sub_c[0]),
        .c(c[H-1:0]), .gg(sub_g[0]), .gp(sub_p[0])
      );
      la_tree #(.W(H)) hi_i (
        .g(g[W-1:H]), .p(p[W-1:H]), .cin(sub_c[1]),
        .c(c[W-1:H]), .gg(sub_g[1]), .gp(sub_p[1])
      );
      la_cell root_i (
        .g(sub_g), .p(sub_p), .cin(cin), .c(sub_c), .gg(gg), .gp(gp)
      );
    end
  endgenerate
endmodule

// File: rtl/alu_slice.sv
module alu_slice (
  input  logic       a,
  input  logic       b,
  input  logic [2:0] sel,
  input  logic       cin,
  output logic       y,
  output logic       g,
  output logic       p
);
  logic b_eff;
  logic cin_g;

  assign b_eff = b ^ sel[0];
  assign cin_g = cin & sel[1];
  assign g     = a & b_eff;
  assign p     = a ^ b_eff;
  assign y     = alu_pipe_pkg::bit_result(a, b, sel, p, cin_g);
endmodule

// File: rtl/alu32_pipe.sv
module alu32_pipe #(
  parameter int W = alu_pipe_pkg::DATA_W
) (
  input  logic         clk,
  input  logic [W-1:0] opa_in,
  input  logic [W-1:0] opb_in,
  input  logic [2:0]   op_sel,
  input  logic         carry_in,
  output logic [W-1:0] result_out
);
  logic [W-1:0] opa_q;
  logic [W-1:0] opb_q;
  logic [W-1:0] alu_y;
  logic [W-1:0] bit_g;
  logic [W-1:0] bit_p;
  logic [W-1:0] bit_c;
  logic         grp_g;
  logic         grp_p;
  logic         cout_w;

  pipe_reg #(.W(W)) a_reg_i (.clk(clk), .d(opa_in), .q(opa_q));
  pipe_reg #(.W(W)) b_reg_i (.clk(clk), .d(opb_in), .q(opb_q));

  generate
    for (genvar i = 0; i < W; i++) begin : g_slice
      alu_slice slice_i (
        .a(opa_q[i]), .b(opb_q[i]), .sel(op_sel), .cin(bit_c[i]),
        .y(alu_y[i]), .g(bit_g[i]), .p(bit_p[i])
      );
    end
  endgenerate

  la_tree #(.W(W)) carry_i (
    .g(bit_g), .p(bit_p), .cin(carry_in),
    .c(bit_c), .gg(grp_g), .gp(grp_p)
  );

  // Carry out of the top bit, brought out for the checker.
  assign cout_w = grp_g | (grp_p & carry_in);

  pipe_reg #(.W(W)) d_reg_i (.clk(clk), .d(alu_y), .q(result_out));
endmodule

// File: rtl/alu32_pipe_chk.sv
module alu32_pipe_chk #(
  parameter int W = alu_pipe_pkg::DATA_W
) (
  input logic         clk,
  input logic [W-1:0] opa_in,
  input logic [W-1:0] opb_in,
  input logic [2:0]   op_sel,
  input logic         carry_in,
  input logic [W-1:0] result_out,
  input logic [W-1:0] opa_q,
  input logic [W-1:0] opb_q,
  input logic [W-1:0] alu_y,
  input logic         cout_w
);
  import alu_pipe_pkg::*;

  // No reset in the block: checks arm once enough history exists.
  logic [1:0] edges_seen = 2'd0;
  logic       armed;

  always_ff @(posedge clk) begin
    if (edges_seen != 2'd3) edges_seen <= edges_seen + 2'd1;
  end
  assign armed = (edges_seen == 2'd3);

  a_r1_opa_capture: assert property (@(posedge clk) disable iff (!armed)
    opa_q == $past(opa_in));

  a_r2_opb_capture: assert property (@(posedge clk) disable iff (!armed)
    opb_q == $past(opb_in));

  a_r3_output_stage: assert property (@(posedge clk) disable iff (!armed)
    result_out == $past(alu_y));

  // R4, R5, R7: full function with operands two edges back, controls one back
  a_r4_function: assert property (@(posedge clk) disable iff (!armed)
    result_out == word_model($past(opa_in, 2), $past(opb_in, 2),
                             $past(op_sel), $past(carry_in)));

  a_r6_carry_out: assert property (@(posedge clk) disable iff (!armed)
    (op_sel == OP_ADD) |-> (cout_w == add_carry(opa_q, opb_q, carry_in)));

  a_r8_zero_code: assert property (@(posedge clk) disable iff (!armed)
    ($past(op_sel) == OP_ZERO) |-> (result_out == '0));

endmodule

bind alu32_pipe alu32_pipe_chk #(.W(W)) chk_i (
  .clk(clk), .opa_in(opa_in), .opb_in(opb_in), .op_sel(op_sel),
  .carry_in(carry_in), .result_out(result_out), .opa_q(opa_q),
  .opb_q(opb_q), .alu_y(alu_y), .cout_w(cout_w)
);

// File: tb/alu32_pipe_tb_top.sv
`timescale 1ns/1ps
module alu32_pipe_tb_top;
  logic        clk = 1'b0;
  logic [31:0] opa_in = '0;
  logic [31:0] opb_in = '0;
  logic [2:0]  op_sel = '0;
  logic        carry_in = 1'b0;
  logic [31:0] result_out;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  alu32_pipe dut_i (
    .clk(clk), .opa_in(opa_in), .opb_in(opb_in), .op_sel(op_sel),
    .carry_in(carry_in), .result_out(result_out)
  );

  // Bench's own expectation, by operation code.
  function automatic logic [31:0] expect_of(logic [31:0] a, logic [31:0] b,
                                            logic [2:0] s, logic c);
    case (s)
      3'd0: return a ^ b;
      3'd1: return ~(a ^ b);
      3'd2: return a + b + {31'd0, c};
      3'd3: return a - b - {31'd0, ~c};
      3'd4: return a | b;
      3'd5: return ~(a | b);
      3'd6: return a & b;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  // Drive one vector with controls held, read after two rising edges.
  task automatic run_one(string req, logic [31:0] a, logic [31:0] b,
                         logic [2:0] s, logic c);
    @(negedge clk);
    opa_in = a; opb_in = b; op_sel = s; carry_in = c;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check(req, result_out, expect_of(a, b, s, c));
  endtask

  task automatic t_first_result;   // R3: first defined output
    run_one("R3 first", 32'h1234_5678, 32'h0F0F_0F0F, 3'b000, 1'b0);
  endtask

  task automatic t_logic_ops;   // R5
    run_one("R5 xor",  32'hA5A5_0F0F, 32'h5A5A_00FF, 3'b000, 1'b0);
    run_one("R5 xnor", 32'hA5A5_0F0F, 32'h5A5A_00FF, 3'b001, 1'b0);
    run_one("R5 or",   32'h8000_0001, 32'h0100_8000, 3'b100, 1'b0);
    run_one("R5 nor",  32'h8000_0001, 32'h0100_8000, 3'b101, 1'b0);
    run_one("R5 and",  32'hFFFF_0000, 32'h0FF0_0FF0, 3'b110, 1'b0);
  endtask

  task automatic t_arith;   // R6, R7
    run_one("R6 add c0", 32'h1234_5678, 32'h1111_1111, 3'b010, 1'b0);
    run_one("R6 add c1", 32'h7FFF_FFFF, 32'h0000_0000, 3'b010, 1'b1);
    run_one("R6 add carry ripple", 32'h0000_FFFF, 32'h0000_0001, 3'b010, 1'b0);
    run_one("R7 sub c1", 32'd1000, 32'd1, 3'b011, 1'b1);
    run_one("R7 sub c0", 32'd1000, 32'd1, 3'b011, 1'b0);
    run_one("R7 sub neg", 32'd5, 32'd9, 3'b011, 1'b1);
  endtask

  task automatic t_zero;   // R8
    run_one("R8 zero", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b111, 1'b1);
  endtask

  task automatic t_cin_ignored;   // R9: logic result with carry_in = 1
    run_one("R9 xor c1", 32'h0000_00F0, 32'h0000_000F, 3'b000, 1'b1);
    run_one("R9 and c1", 32'h0000_0000, 32'h0000_0000, 3'b110, 1'b1);
    run_one("R9 nor c1", 32'hFFFF_FFFE, 32'h0000_0000, 3'b101, 1'b1);
  endtask

  task automatic t_wrap;   // R10
    run_one("R10 max+1", 32'hFFFF_FFFF, 32'h0000_0000, 3'b010, 1'b1);
    run_one("R10 max+1 via b", 32'hFFFF_FFFF, 32'h0000_0001, 3'b010, 1'b0);
    run_one("R10 0-1", 32'h0000_0000, 32'h0000_0001, 3'b011, 1'b1);
  endtask

  // R3: result must not move after only one edge.
  task automatic t_latency;
    logic [31:0] old_r;
    run_one("R3 latency setup", 32'd7, 32'd3, 3'b010, 1'b0);
    old_r = 32'd10;
    @(negedge clk);
    opa_in = 32'd100; opb_in = 32'd23;
    @(posedge clk);
    @(negedge clk);
    check("R3 hold after one edge", result_out, old_r);
    @(posedge clk);
    @(negedge clk);
    check("R3 due after two edges", result_out, 32'd123);
  endtask

  // R1, R2, R4: new operands every cycle, controls one cycle behind.
  task automatic t_stream;
    logic [31:0] va [6] = '{32'h0000_0001, 32'hFFFF_FFFF, 32'h8000_0000,
                            32'h1357_9BDF, 32'h0000_0000, 32'hDEAD_BEEF};
    logic [31:0] vb [6] = '{32'h0000_0002, 32'h0000_0001, 32'h8000_0000,
                            32'h2468_ACE0, 32'h0000_0001, 32'h0F0F_F0F0};
    logic [2:0]  vs [6] = '{3'b010, 3'b010, 3'b011, 3'b000, 3'b011, 3'b110};
    logic        vc [6] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (k >= 2)
        check("R4 stream", result_out,
              expect_of(va[k-2], vb[k-2], vs[k-2], vc[k-2]));
      if (k < 6) begin
        opa_in = va[k]; opb_in = vb[k];
      end
      if (k >= 1 && k <= 6) begin
        op_sel = vs[k-1]; carry_in = vc[k-1];
      end
    end
  endtask

  initial begin
    t_first_result();
    t_logic_ops();
    t_arith();
    t_zero();
    t_cin_ignored();
    t_wrap();
    t_latency();
    t_stream();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule